// File: doc/BRIEF.md
# Constant-Weight Precharged Bus Codec

This block recodes data words for a single-rail precharged bus. Every word that goes onto the lines then pulls down the same number of lines, whatever its value. On the transmit side, the word is complemented when it holds too many zeros, and a flag line records that choice. A group of balance lines then pulls down as many extra lines as are needed to bring the zero count over payload and balance lines to exactly half the data width. On the receive side, the payload is restored from the invert flag, and the zero count is checked so that a malformed word is flagged.

Both halves model the two bus phases:

- **Precharge:** in any cycle with no word, every line is held high.
- **Evaluation:** the coded word is driven onto the lines.

The invert flag is kept out of the balancing. A parameter selects how it is carried:

- as a single line that is not counted, or
- with a companion line of opposite polarity, so that the flag pair always shows exactly one zero.

For an 8-bit word, the bus has 8 payload lines, 4 balance lines, the invert line and its companion.

Top module: `cwb_bus`

## Requirements
- R1: While reset is held low at a clock edge, every bit of line_out is 1 and line_eval_out, rx_valid and rx_err are 0 after that edge.
- R2: After a clock edge at which tx_valid was low, line_out is all ones (precharge) and line_eval_out is 0.
- R3: After a clock edge at which tx_valid was high, line_out carries the coded word for tx_data and line_eval_out is 1, for exactly that one cycle.
- R4: Line bits [DATA_W-1:0] carry the payload. When tx_data holds more than DATA_W/2 zeros, the payload is ~tx_data and the invert line (bit DATA_W+DATA_W/2) is 1. Otherwise the payload is tx_data and the invert line is 0. A word with exactly DATA_W/2 zeros is sent unchanged.
- R5: A coded payload never holds more than DATA_W/2 zeros.
- R6: Balance line i (line bit DATA_W+i, for i from 0 to DATA_W/2-1) is 0 exactly when i < DATA_W/2 minus the payload zero count, so the balance zeros form a thermometer from the lowest index upward.
- R7: In every evaluation cycle, the payload and balance lines together hold exactly DATA_W/2 zeros.
- R8: With INV_PAIR=1, line bit DATA_W+DATA_W/2+1 is the complement of the invert line during evaluation.
- R9: After a clock edge at which line_eval_in was high, rx_valid is 1 and rx_data equals line_in[DATA_W-1:0], complemented bit by bit when the invert line of line_in was 1.
- R10: After a clock edge at which line_eval_in was high, rx_err is 1 exactly when line_in[DATA_W+DATA_W/2-1:0] does not hold DATA_W/2 zeros, or when INV_PAIR=1 and the invert line equals its companion. rx_err is never 1 without rx_valid.
- R11: After a clock edge at which line_eval_in was low, rx_valid and rx_err are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid | input | 1 | A data word is offered this cycle |
| tx_data | input | DATA_W | Data word to encode |
| line_out | output | LINE_W | Coded bus lines, all ones during precharge |
| line_eval_out | output | 1 | High while line_out carries a coded word |
| line_in | input | LINE_W | Bus lines at the receiver |
| line_eval_in | input | 1 | High while line_in carries a coded word |
| rx_data | output | DATA_W | Decoded data word |
| rx_valid | output | 1 | rx_data and rx_err are valid |
| rx_err | output | 1 | Received word breaks the constant-weight rule |

## Verification
The encoder has one register stage, so the coded lines for a word offered before edge k are compared in the half cycle after edge k. The line word is expected back at the precharge value after edge k+1. The receive path also has one register, so rx_data, rx_valid and rx_err are sampled after the edge that follows the line word's evaluation cycle, and rx_valid is expected low one edge later. All sampling happens at falling edges, and stimulus changes only there. Every one of the 256 words is sent once, followed by seeded random words with single-line and flag-line corruptions on the loopback path to provoke the error flag.

// File: rtl/cwb_pkg.sv
// Package: shared types for the constant-weight bus codec.
// Assumes nothing beyond IEEE 1800-2017.
package cwb_pkg;

    // Bus phase seen on the lines: all high, or carrying a coded word.
    typedef enum logic {
        PH_PRECHARGE = 1'b0,
        PH_EVALUATE  = 1'b1
    } bus_phase_e;

    // Width of a counter able to hold the values 0..n.
    function automatic int count_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/cwb_zero_count.sv
// Module: cwb_zero_count
// Counts the zero bits of a vector, combinationally.
// Assumes CNT_W is wide enough to hold the value W.
module cwb_zero_count #(
    parameter int W     = 8,
    parameter int CNT_W = 4
) (
    input  logic [W-1:0]     vec,
    output logic [CNT_W-1:0] zeros
);

    // Sum the inverted bits of the vector.
    always_comb begin
        zeros = '0;
        for (int i = 0; i < W; i++) begin
            zeros = zeros + CNT_W'(!vec[i]);
        end
    end

endmodule

// File: rtl/cwb_encoder.sv
// Module: cwb_encoder
// Transmit side: inverts a word with too many zeros, fills the balance lines
// as a thermometer so that payload plus balance hold DATA_W/2 zeros, and
// registers the result. Lines stay at all ones in cycles with no word.
// Assumes DATA_W is even.
module cwb_encoder
    import cwb_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter bit INV_PAIR = 1'b1,
    localparam int BAL_W   = DATA_W / 2,
    localparam int INV_IDX = DATA_W + BAL_W,
    localparam int LINE_W  = DATA_W + BAL_W + 1 + (INV_PAIR ? 1 : 0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic [LINE_W-1:0] line_out,
    output logic              line_eval_out
);

    localparam int CNT_W = count_width(DATA_W);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(BAL_W);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

    logic [CNT_W-1:0]  data_zeros;
    logic [CNT_W-1:0]  pay_zeros;
    logic [CNT_W-1:0]  bal_need;
    logic              do_invert;
    logic [DATA_W-1:0] payload;
    logic [BAL_W-1:0]  balance;
    logic [LINE_W-1:0] line_nxt;
    logic [LINE_W-1:0] line_q;
    bus_phase_e        phase_q;

    cwb_zero_count #(.W(DATA_W), .CNT_W(CNT_W)) u_zc (
        .vec   (tx_data),
        .zeros (data_zeros)
    );

    // Decide inversion and derive the payload zero count without a second counter.
    always_comb begin
        do_invert = (data_zeros > HALF);
        payload   = do_invert ? ~tx_data : tx_data;
        pay_zeros = do_invert ? (FULL - data_zeros) : data_zeros;
        bal_need  = HALF - pay_zeros;
    end

    // Thermometer fill: balance line i goes low when i is below the shortfall.
    for (genvar i = 0; i < BAL_W; i++) begin : g_bal
        localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
        assign balance[i] = !(IDX < bal_need);
    end

    // Assemble the line word; the optional companion flag line sits on top.
    if (INV_PAIR) begin : g_pair
        assign line_nxt = {~do_invert, do_invert, balance, payload};
    end else begin : g_single
        assign line_nxt = {do_invert, balance, payload};
    end

    // Register one evaluation cycle per word, precharge otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q  <= '1;
            phase_q <= PH_PRECHARGE;
        end else if (tx_valid) begin
            line_q  <= line_nxt;
            phase_q <= PH_EVALUATE;
        end else begin
            line_q  <= '1;
            phase_q <= PH_PRECHARGE;
        end
    end

    assign line_out      = line_q;
    assign line_eval_out = (phase_q == PH_EVALUATE);

    // R2
    precharge_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_eval_out |-> (&line_out));

    // R3
    eval_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> line_eval_out);

    // R4
    payload_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> (line_out[DATA_W-1:0] ==
                      ($past(tx_data) ^ {DATA_W{line_out[INV_IDX]}})));

    // R5
    payload_zero_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_eval_out |-> ($countones(~line_out[DATA_W-1:0]) <= BAL_W));

    // R7
    constant_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_eval_out |-> ($countones(~line_out[INV_IDX-1:0]) == BAL_W));

    if (INV_PAIR) begin : g_pair_chk
        // R8
        flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
            line_eval_out |-> (line_out[INV_IDX+1] != line_out[INV_IDX]));
    end

endmodule

// File: rtl/cwb_decoder.sv
// Module: cwb_decoder
// Receive side: restores the data word from the invert line and flags a word
// whose payload plus balance lines do not hold DATA_W/2 zeros, or whose flag
// pair is not complementary. Output is registered one cycle after evaluation.
// Assumes DATA_W is even.
module cwb_decoder
    import cwb_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter bit INV_PAIR = 1'b1,
    localparam int BAL_W   = DATA_W / 2,
    localparam int INV_IDX = DATA_W + BAL_W,
    localparam int LINE_W  = DATA_W + BAL_W + 1 + (INV_PAIR ? 1 : 0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line_in,
    input  logic              line_eval_in,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_err
);

    localparam int CNT_W = count_width(INV_IDX);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(BAL_W);

    logic [CNT_W-1:0]  wt_zeros;
    logic              flag_bad;
    logic              word_bad;
    logic [DATA_W-1:0] data_nxt;
    logic [DATA_W-1:0] data_q;
    logic              valid_q;
    logic              err_q;

    cwb_zero_count #(.W(INV_IDX), .CNT_W(CNT_W)) u_zc (
        .vec   (line_in[INV_IDX-1:0]),
        .zeros (wt_zeros)
    );

    // A flag pair must differ; a single flag line cannot be checked.
    if (INV_PAIR) begin : g_pair
        assign flag_bad = (line_in[INV_IDX+1] == line_in[INV_IDX]);
    end else begin : g_single
        assign flag_bad = 1'b0;
    end

    // Undo the inversion and judge the weight of the word.
    always_comb begin
        data_nxt = line_in[DATA_W-1:0] ^ {DATA_W{line_in[INV_IDX]}};
        word_bad = (wt_zeros != HALF) || flag_bad;
    end

    // Capture a word in each evaluation cycle; drop valid otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else if (line_eval_in) begin
            data_q  <= data_nxt;
            valid_q <= 1'b1;
            err_q   <= word_bad;
        end else begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end
    end

    assign rx_data  = data_q;
    assign rx_valid = valid_q;
    assign rx_err   = err_q;

    // R9
    rx_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_eval_in |=> rx_valid);

    // R10
    err_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> rx_valid);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_eval_in |=> (!rx_valid && !rx_err));

endmodule

// File: rtl/cwb_bus.sv
// Module: cwb_bus
// Top: constant-weight encoder driving line_out, and decoder reading line_in.
// The two sides share only clock and reset, so the lines can be wired across
// a bus or looped back.
// Assumes DATA_W is even.
module cwb_bus #(
    parameter int DATA_W   = 8,
    parameter bit INV_PAIR = 1'b1,
    localparam int LINE_W  = DATA_W + DATA_W / 2 + 1 + (INV_PAIR ? 1 : 0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic [LINE_W-1:0] line_out,
    output logic              line_eval_out,
    input  logic [LINE_W-1:0] line_in,
    input  logic              line_eval_in,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_err
);

    cwb_encoder #(.DATA_W(DATA_W), .INV_PAIR(INV_PAIR)) u_enc (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_valid      (tx_valid),
        .tx_data       (tx_data),
        .line_out      (line_out),
        .line_eval_out (line_eval_out)
    );

    cwb_decoder #(.DATA_W(DATA_W), .INV_PAIR(INV_PAIR)) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_in      (line_in),
        .line_eval_in (line_eval_in),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_err       (rx_err)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> ((&line_out) && !line_eval_out && !rx_valid && !rx_err));

endmodule

// File: tb/sim_cwb_bus.sv
// Bench for cwb_bus: exhaustive and seeded random words over a loopback
// with optional line corruption, checked against bench-side models.
module sim_cwb_bus;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 8;
    localparam int BW   = DW / 2;
    localparam int IDX  = DW + BW;
    localparam int LW   = DW + BW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_valid = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic [LW-1:0] line_out;
    logic          line_eval_out;
    logic [LW-1:0] flip = '0;
    logic [LW-1:0] line_in;
    logic          line_eval_in;
    logic [DW-1:0] rx_data;
    logic          rx_valid;
    logic          rx_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    assign line_in      = line_out ^ flip;
    assign line_eval_in = line_eval_out;

    cwb_bus u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_valid      (tx_valid),
        .tx_data       (tx_data),
        .line_out      (line_out),
        .line_eval_out (line_eval_out),
        .line_in       (line_in),
        .line_eval_in  (line_eval_in),
        .rx_data       (rx_data),
        .rx_valid      (rx_valid),
        .rx_err        (rx_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int zeros_of(input logic [31:0] v, input int w);
        int z = 0;
        for (int i = 0; i < w; i++) if (!v[i]) z++;
        return z;
    endfunction

    // Expected coded word from the requirements R4, R6, R8.
    function automatic logic [LW-1:0] model_line(input logic [DW-1:0] d);
        logic [LW-1:0] l;
        logic inv = zeros_of(32'(d), DW) > BW;
        logic [DW-1:0] p = inv ? ~d : d;
        int need = BW - zeros_of(32'(p), DW);
        l[DW-1:0] = p;
        for (int i = 0; i < BW; i++) l[DW+i] = !(i < need);
        l[IDX]   = inv;
        l[IDX+1] = ~inv;
        return l;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Send one word, optionally corrupting the loopback, and check every phase.
    task automatic send(input logic [DW-1:0] d, input logic [LW-1:0] fm);
        logic [LW-1:0] exp_l = model_line(d);
        logic [LW-1:0] rl    = exp_l ^ fm;
        logic [DW-1:0] exp_d = rl[DW-1:0] ^ {DW{rl[IDX]}};
        logic exp_e = (zeros_of(32'(rl[IDX-1:0]), IDX) != BW) || (rl[IDX] == rl[IDX+1]);
        tx_data  = d;
        tx_valid = 1'b1;
        flip     = fm;
        @(negedge clk);
        tx_valid = 1'b0;
        // R3 R4 R6 R8: coded word one edge after valid
        check(line_eval_out === 1'b1, "R3 eval", 32'(line_eval_out), 1);
        check(line_out === exp_l, "R3/R4/R6/R8 line", 32'(line_out), 32'(exp_l));
        // R5 R7: weight rules on the lines
        check(zeros_of(32'(line_out[DW-1:0]), DW) <= BW, "R5 payload zeros",
              32'(zeros_of(32'(line_out[DW-1:0]), DW)), BW);
        check(zeros_of(32'(line_out[IDX-1:0]), IDX) == BW, "R7 weight",
              32'(zeros_of(32'(line_out[IDX-1:0]), IDX)), BW);
        @(negedge clk);
        // R2: back to precharge
        check(&line_out && !line_eval_out, "R2 precharge", 32'(line_out), 32'({LW{1'b1}}));
        // R9 R10: decoded result
        check(rx_valid === 1'b1, "R9 valid", 32'(rx_valid), 1);
        check(rx_data === exp_d, "R9 data", 32'(rx_data), 32'(exp_d));
        check(rx_err === exp_e, "R10 err", 32'(rx_err), 32'(exp_e));
        flip = '0;
        @(negedge clk);
        // R11: idle receiver quiet
        check(!rx_valid && !rx_err, "R11 idle", 32'({rx_valid, rx_err}), 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(&line_out, "R1 lines", 32'(line_out), 32'({LW{1'b1}}));
        check(!line_eval_out && !rx_valid && !rx_err, "R1 flags",
              32'({line_eval_out, rx_valid, rx_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed corners: all zeros, all ones, tie weight, one over the tie.
        send(8'h00, '0);
        send(8'hFF, '0);
        send(8'h0F, '0);
        send(8'h07, '0);
        // Exhaustive round trip, R4 to R9.
        for (int v = 0; v < 256; v++) send(DW'(v), '0);
        // Random words with corruption, R10.
        for (int k = 0; k < 300; k++) begin
            logic [DW-1:0] d = DW'($urandom);
            int sel = $urandom % 4;
            logic [LW-1:0] fm = '0;
            if (sel == 1) fm[$urandom % IDX] = 1'b1;
            else if (sel == 2) fm[IDX] = 1'b1;
            else if (sel == 3) fm[IDX+1] = 1'b1;
            send(d, fm);
        end
        // Both flag lines flipped: weight and pair rules hold, data complemented.
        send(8'h5A, {2'b11, {IDX{1'b0}}});
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule